// File: doc/BRIEF.md
# Debug Module Control and Authentication Gate

This block holds the run-control registers of a debug module that serves a parameterised number of harts. A debugger writes and reads 32-bit registers through a simple strobe port. Through the control register it selects one hart, sets or clears that hart's halt request, asks it to resume, and requests a reset of that hart or of every hart. Each hart reports three events back: it has halted, it is resuming, and it has come out of reset. The block keeps a halted, resume-acknowledge and have-reset flag for every hart. It reports them for the selected hart through a status register.

A challenge-response lock stands in front of the register file. Until the debugger writes the key register with the current challenge plus a fixed secret, writes to every register except the key and control registers are refused. A control write may then change only the active bit. A wrong key locks the module and draws a new challenge from a free-running 32-bit LFSR. Writes to registers that live outside this block, such as abstract-command and system-bus registers, leave as a forwarded write strobe, and that strobe is gated by the lock. When the `REQ_AUTH` parameter is 0 the module comes out of reset already unlocked.

Top module: `dbgm_ctrl`

## Requirements
- R1: `fwd_we` rises with `reg_we` only for an address other than control (0x10), status (0x11) and key (0x30), and only while the module is authenticated. While locked, such writes are dropped.
- R2: A read of the key register (0x30) returns the current challenge. Writing challenge + SECRET to it sets authenticated. Any other value clears authenticated and replaces the challenge with a new value taken from the LFSR.
- R3: A control write whose active bit (bit 0) is 1 while the module is inactive first clears the stored control fields, every hart's halt request and resume flag, and authenticated, and takes a new challenge. While not authenticated, a control write changes only the active bit.
- R4: An authenticated control write with active=1 loads the system reset (bit 1), hart reset (bit 2), hart select (bits 16 and up), resume request (bit 30) and halt request (bit 31) fields. The halt request value is stored for the newly selected hart. Bit 3 set clears that hart's have-reset flag.
- R5: A resume request sets the selected hart's `resume_req_o` bit and clears its resume-ack flag. A resuming report from a hart clears its halted flag and its `resume_req_o` bit, and sets its resume-ack flag.
- R6: A halted report sets that hart's halted flag. A reset report sets its have-reset flag and clears its halted flag.
- R7: The status register (0x11) describes the selected hart only, with any/all pairs at bits 8/9 halted, 10/11 running, 12/13 nonexistent, 14/15 resume-ack and 16/17 have-reset. A select value at or above the hart count reads as nonexistent, with every other pair at 0.
- R8: Status bits 3:0 read 2, bit 5 (implicit breakpoint) reads 1, and bit 4 reads the authenticated state.
- R9: An authenticated control write with system reset set pulses `hart_rst_o` on every hart for one cycle after the write. With hart reset set, the pulse goes to the selected hart only.
- R10: Bit 31 of a control read shows the stored halt request of the currently selected hart, not the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| fwd_we | output | 1 | Gated write strobe for registers held outside this block |
| halt_req_o | output | N_HARTS | Per-hart halt request level |
| resume_req_o | output | N_HARTS | Per-hart pending resume request |
| hart_rst_o | output | N_HARTS | Per-hart one-cycle reset request |
| halted_i | input | N_HARTS | Per-hart halted report, one-cycle pulse |
| resuming_i | input | N_HARTS | Per-hart resuming report, one-cycle pulse |
| reset_evt_i | input | N_HARTS | Per-hart reset-complete report, one-cycle pulse |

## Verification
The assertions assume that hart reports are single-cycle pulses. They also assume that a hart never reports resuming and halted in the same cycle, because that ordering is settled inside the tracker and not at the ports. They further assume that the key register is written only by the debugger, so every rise of authenticated traces back to a key write. The stimulus drives each report as a one-cycle pulse on one hart at a time. It keeps register writes one cycle long and spaced by at least one idle cycle, and it never sends a resume request in the same cycle as a resuming report.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] A_CTRL = 7'h10;
  localparam logic [ADDR_W-1:0] A_STAT = 7'h11;
  localparam logic [ADDR_W-1:0] A_KEY  = 7'h30;

  // control field positions
  localparam int C_ACTIVE = 0;
  localparam int C_SYSRST = 1;
  localparam int C_HARTRST = 2;
  localparam int C_ACKRST = 3;
  localparam int C_SEL = 16;
  localparam int C_RESUME = 30;
  localparam int C_HALT = 31;

  // status field positions
  localparam int S_AUTH = 4;
  localparam int S_IMPEB = 5;
  localparam int S_HALT = 8;
  localparam int S_RUN = 10;
  localparam int S_NONEX = 12;
  localparam int S_RACK = 14;
  localparam int S_HRST = 16;
  localparam logic [3:0] STAT_VERSION = 4'd2;

  typedef struct packed {
    logic exists;
    logic halted;
    logic resume_ack;
    logic have_reset;
    logic halt_req;
  } hart_view_t;

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  function automatic logic [31:0] status_word(input hart_view_t v, input logic auth);
    logic [31:0] w;
    logic hal, run, nex, rck, hrs;
    hal = v.exists & v.halted;
    run = v.exists & ~v.halted;
    nex = ~v.exists;
    rck = v.exists & v.resume_ack;
    hrs = v.exists & v.have_reset;
    w = '0;
    w[3:0] = STAT_VERSION;
    w[S_AUTH] = auth;
    w[S_IMPEB] = 1'b1;
    w[S_HALT +: 2] = {2{hal}};
    w[S_RUN +: 2] = {2{run}};
    w[S_NONEX +: 2] = {2{nex}};
    w[S_RACK +: 2] = {2{rck}};
    w[S_HRST +: 2] = {2{hrs}};
    return w;
  endfunction
endpackage

// File: rtl/dbgm_lfsr.sv
module dbgm_lfsr #(
  parameter logic [31:0] SEED = 32'h1D2C_3B4A
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] state_o
);
  import dbgm_pkg::*;
  logic [31:0] st_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED;
    else        st_q <= lfsr_step(st_q);
  end
  assign state_o = st_q;
endmodule

// File: rtl/dbgm_hart_track.sv
module dbgm_hart_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic load_i,
  input  logic halt_val_i,
  input  logic resume_i,
  input  logic ack_i,
  input  logic halted_evt_i,
  input  logic resuming_evt_i,
  input  logic reset_evt_i,
  output logic halt_req_o,
  output logic resume_pend_o,
  output logic halted_o,
  output logic resume_ack_o,
  output logic have_reset_o
);
  logic hreq_q, rpend_q, halted_q, rack_q, hrst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hreq_q <= 1'b0;
      rpend_q <= 1'b0;
      halted_q <= 1'b0;
      rack_q <= 1'b0;
      hrst_q <= 1'b0;
    end else begin
      if (clr_i) begin
        hreq_q <= 1'b0;
        rpend_q <= 1'b0;
      end
      if (load_i) hreq_q <= halt_val_i;
      if (halted_evt_i) halted_q <= 1'b1;
      if (resuming_evt_i) begin
        halted_q <= 1'b0;
        rpend_q <= 1'b0;
        rack_q <= 1'b1;
      end
      if (load_i && ack_i) hrst_q <= 1'b0;
      if (reset_evt_i) begin
        hrst_q <= 1'b1;
        halted_q <= 1'b0;
      end
      if (load_i && resume_i) begin
        rpend_q <= 1'b1;
        rack_q <= 1'b0;
      end
    end
  end

  assign halt_req_o = hreq_q;
  assign resume_pend_o = rpend_q;
  assign halted_o = halted_q;
  assign resume_ack_o = rack_q;
  assign have_reset_o = hrst_q;
endmodule

// File: rtl/dbgm_sel_view.sv
module dbgm_sel_view
  import dbgm_pkg::*;
#(
  parameter int N_HARTS = 4,
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [N_HARTS-1:0] halted_v,
  input  logic [N_HARTS-1:0] rack_v,
  input  logic [N_HARTS-1:0] hrst_v,
  input  logic [N_HARTS-1:0] hreq_v,
  output hart_view_t         view_o
);
  always_comb begin
    view_o = '0;
    for (int i = 0; i < N_HARTS; i++) begin
      if (sel_i == SEL_W'(i)) begin
        view_o.exists = 1'b1;
        view_o.halted = halted_v[i];
        view_o.resume_ack = rack_v[i];
        view_o.have_reset = hrst_v[i];
        view_o.halt_req = hreq_v[i];
      end
    end
  end
endmodule

// File: rtl/dbgm_ctrl.sv
module dbgm_ctrl
  import dbgm_pkg::*;
#(
  parameter int          N_HARTS = 4,
  parameter int          SEL_W = 4,
  parameter bit          REQ_AUTH = 1'b1,
  parameter logic [31:0] SECRET = 32'h3C5A_96E1,
  parameter logic [31:0] SEED = 32'h1D2C_3B4A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [6:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               fwd_we,
  output logic [N_HARTS-1:0] halt_req_o,
  output logic [N_HARTS-1:0] resume_req_o,
  output logic [N_HARTS-1:0] hart_rst_o,
  input  logic [N_HARTS-1:0] halted_i,
  input  logic [N_HARTS-1:0] resuming_i,
  input  logic [N_HARTS-1:0] reset_evt_i
);
  localparam logic AUTH_INIT = ~REQ_AUTH;

  logic              active_q, srst_q, hrst_q, resume_q, auth_q;
  logic [SEL_W-1:0]  sel_q;
  logic [31:0]       chal_q, lfsr_v;
  logic [N_HARTS-1:0] pulse_q;
  logic [N_HARTS-1:0] halted_v, rack_v, hrstf_v, hreq_v;
  hart_view_t        view;

  // named write events
  logic ctl_wr, key_wr, raise, auth_now, ctl_load, key_ok, key_fail;
  logic [SEL_W-1:0] sel_new;

  assign ctl_wr   = reg_we && (reg_addr == A_CTRL);
  assign key_wr   = reg_we && (reg_addr == A_KEY);
  assign raise    = ctl_wr && !active_q && reg_wdata[C_ACTIVE];
  assign auth_now = raise ? AUTH_INIT : auth_q;
  assign ctl_load = ctl_wr && auth_now && reg_wdata[C_ACTIVE];
  assign sel_new  = reg_wdata[C_SEL +: SEL_W];
  assign key_ok   = key_wr && REQ_AUTH && (reg_wdata == chal_q + SECRET);
  assign key_fail = key_wr && REQ_AUTH && (reg_wdata != chal_q + SECRET);

  dbgm_lfsr #(.SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state_o(lfsr_v)
  );

  genvar g;
  generate
    for (g = 0; g < N_HARTS; g++) begin : g_hart
      logic hit;
      assign hit = ctl_load && (sel_new == SEL_W'(g));
      dbgm_hart_track u_trk (
        .clk(clk), .rst_n(rst_n),
        .clr_i(raise),
        .load_i(hit),
        .halt_val_i(reg_wdata[C_HALT]),
        .resume_i(reg_wdata[C_RESUME]),
        .ack_i(reg_wdata[C_ACKRST]),
        .halted_evt_i(halted_i[g]),
        .resuming_evt_i(resuming_i[g]),
        .reset_evt_i(reset_evt_i[g]),
        .halt_req_o(hreq_v[g]),
        .resume_pend_o(resume_req_o[g]),
        .halted_o(halted_v[g]),
        .resume_ack_o(rack_v[g]),
        .have_reset_o(hrstf_v[g])
      );
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q[g] <= 1'b0;
        else pulse_q[g] <= ctl_load &&
                           (reg_wdata[C_SYSRST] || (reg_wdata[C_HARTRST] && sel_new == SEL_W'(g)));
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      srst_q <= 1'b0;
      hrst_q <= 1'b0;
      resume_q <= 1'b0;
      sel_q <= '0;
      auth_q <= AUTH_INIT;
      chal_q <= SEED;
    end else begin
      if (raise) begin
        srst_q <= 1'b0;
        hrst_q <= 1'b0;
        resume_q <= 1'b0;
        sel_q <= '0;
        auth_q <= AUTH_INIT;
        chal_q <= lfsr_v;
      end
      if (ctl_wr) active_q <= reg_wdata[C_ACTIVE];
      if (ctl_load) begin
        srst_q <= reg_wdata[C_SYSRST];
        hrst_q <= reg_wdata[C_HARTRST];
        resume_q <= reg_wdata[C_RESUME];
        sel_q <= sel_new;
      end
      if (key_ok) auth_q <= 1'b1;
      if (key_fail) begin
        auth_q <= 1'b0;
        chal_q <= lfsr_v;
      end
    end
  end

  dbgm_sel_view #(.N_HARTS(N_HARTS), .SEL_W(SEL_W)) u_view (
    .sel_i(sel_q), .halted_v(halted_v), .rack_v(rack_v),
    .hrst_v(hrstf_v), .hreq_v(hreq_v), .view_o(view)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[C_ACTIVE] = active_q;
        reg_rdata[C_SYSRST] = srst_q;
        reg_rdata[C_HARTRST] = hrst_q;
        reg_rdata[C_SEL +: SEL_W] = sel_q;
        reg_rdata[C_RESUME] = resume_q;
        reg_rdata[C_HALT] = view.halt_req;
      end
      A_STAT: reg_rdata = status_word(view, auth_q);
      A_KEY:  reg_rdata = chal_q;
      default: reg_rdata = '0;
    endcase
  end

  assign fwd_we = reg_we && auth_q &&
                  (reg_addr != A_CTRL) && (reg_addr != A_STAT) && (reg_addr != A_KEY);
  assign halt_req_o = hreq_v;
  assign hart_rst_o = pulse_q;
endmodule

// File: rtl/dbgm_ctrl_chk.sv
module dbgm_ctrl_chk
  import dbgm_pkg::*;
#(
  parameter int N_HARTS = 4,
  parameter bit REQ_AUTH = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_we,
  input logic [6:0]         reg_addr,
  input logic               fwd_we,
  input logic               auth_q,
  input logic               key_fail,
  input logic [31:0]        chal_q,
  input logic [N_HARTS-1:0] hart_rst_o,
  input logic [N_HARTS-1:0] resuming_i,
  input logic [N_HARTS-1:0] reset_evt_i,
  input logic [N_HARTS-1:0] halted_v,
  input logic [N_HARTS-1:0] hrstf_v
);
  assert_fail_locks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (REQ_AUTH && key_fail) |=> !fwd_we);

  assert_unlock_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (REQ_AUTH && $rose(auth_q)) |-> $past(reg_we && reg_addr == A_KEY));

  assert_new_challenge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_fail |=> (chal_q != $past(chal_q)));

  assert_pulse_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|hart_rst_o) |-> $past(reg_we && reg_addr == A_CTRL));

  genvar k;
  generate
    for (k = 0; k < N_HARTS; k++) begin : g_chk
      assert_resume_clears_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resuming_i[k] |=> !halted_v[k]);
      assert_reset_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_evt_i[k] |=> (hrstf_v[k] && !halted_v[k]));
    end
  endgenerate
endmodule

bind dbgm_ctrl dbgm_ctrl_chk #(.N_HARTS(N_HARTS), .REQ_AUTH(REQ_AUTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .fwd_we(fwd_we), .auth_q(auth_q), .key_fail(key_fail), .chal_q(chal_q),
  .hart_rst_o(hart_rst_o), .resuming_i(resuming_i), .reset_evt_i(reset_evt_i),
  .halted_v(halted_v), .hrstf_v(hrstf_v)
);

// File: tb/dbgm_ctrl_tb.sv
module dbgm_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam logic [31:0] SECRET = 32'h3C5A_96E1;
  localparam logic [6:0] A_CTRL = 7'h10, A_STAT = 7'h11, A_KEY = 7'h30, A_EXT = 7'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [6:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic fwd_we;
  logic [N-1:0] halt_req_o, resume_req_o, hart_rst_o;
  logic [N-1:0] halted_i = '0, resuming_i = '0, reset_evt_i = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgm_ctrl #(.N_HARTS(N), .SEL_W(4), .REQ_AUTH(1'b1), .SECRET(SECRET)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fwd_we(fwd_we),
    .halt_req_o(halt_req_o), .resume_req_o(resume_req_o), .hart_rst_o(hart_rst_o),
    .halted_i(halted_i), .resuming_i(resuming_i), .reset_evt_i(reset_evt_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // write that also samples the forwarded strobe before the edge
  task automatic wr_fwd(input logic [6:0] a, input logic [31:0] d, input logic exp, input string req);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    #1;
    chk(req, 32'(fwd_we), 32'(exp));
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse(input int which, input int h);
    @(negedge clk);
    case (which)
      0: halted_i[h] = 1'b1;
      1: resuming_i[h] = 1'b1;
      default: reset_evt_i[h] = 1'b1;
    endcase
    @(negedge clk);
    halted_i = '0; resuming_i = '0; reset_evt_i = '0;
  endtask

  task automatic t_reset_state;
    logic [31:0] v;
    rd(A_STAT, v); chk("R8 status after reset", v, 32'h0000_0C22);
    rd(A_CTRL, v); chk("R4 ctrl after reset", v, 32'h0);
    chk("R4 halt_req after reset", 32'(halt_req_o), 32'h0);
    wr_fwd(A_EXT, 32'h1234, 1'b0, "R1 locked forward write");
  endtask

  task automatic t_locked_ctrl;
    logic [31:0] v;
    wr(A_CTRL, 32'h8001_0001);
    rd(A_CTRL, v); chk("R3 locked ctrl write only active", v, 32'h0000_0001);
    chk("R3 locked ctrl no halt", 32'(halt_req_o), 32'h0);
  endtask

  task automatic t_auth;
    logic [31:0] c, c2, v;
    rd(A_KEY, c);
    wr(A_KEY, c + SECRET + 32'd1);
    rd(A_STAT, v); chk("R2 wrong key stays locked", 32'(v[4]), 32'h0);
    rd(A_KEY, c2); chk("R2 challenge changed", 32'(c2 != c), 32'h1);
    wr(A_KEY, c2 + SECRET);
    rd(A_STAT, v); chk("R2 right key unlocks", 32'(v[4]), 32'h1);
    wr_fwd(A_EXT, 32'h55, 1'b1, "R1 unlocked forward write");
    wr_fwd(A_STAT, 32'h55, 1'b0, "R1 status not forwarded");
  endtask

  task automatic t_halt;
    logic [31:0] v;
    wr(A_CTRL, 32'h8002_0001);
    chk("R4 halt request hart2", 32'(halt_req_o), 32'h4);
    rd(A_CTRL, v); chk("R4 ctrl readback", v, 32'h8002_0001);
    wr(A_CTRL, 32'h0000_0001);
    chk("R10 hart2 halt kept", 32'(halt_req_o), 32'h4);
    rd(A_CTRL, v); chk("R10 live halt of hart0", v, 32'h0000_0001);
    pulse(0, 2);
    wr(A_CTRL, 32'h0002_0001);
    rd(A_STAT, v); chk("R6 R7 hart2 halted status", v, 32'h0000_0332);
  endtask

  task automatic t_resume;
    logic [31:0] v;
    wr(A_CTRL, 32'h4002_0001);
    chk("R5 resume flag set", 32'(resume_req_o), 32'h4);
    rd(A_STAT, v); chk("R5 resume-ack cleared", v, 32'h0000_0332);
    pulse(1, 2);
    chk("R5 resume flag cleared", 32'(resume_req_o), 32'h0);
    rd(A_STAT, v); chk("R5 running and acked", v, 32'h0000_CC32);
  endtask

  task automatic t_have_reset;
    logic [31:0] v;
    pulse(2, 1);
    wr(A_CTRL, 32'h0001_0001);
    rd(A_STAT, v); chk("R6 have-reset hart1", v, 32'h0003_0C32);
    wr(A_CTRL, 32'h0001_0009);
    rd(A_STAT, v); chk("R4 ack clears have-reset", v, 32'h0000_0C32);
  endtask

  task automatic t_nonexist;
    logic [31:0] v;
    wr(A_CTRL, 32'h0005_0001);
    rd(A_STAT, v); chk("R7 sel 5 nonexistent", v, 32'h0000_3032);
  endtask

  task automatic t_reset_req;
    wr(A_CTRL, 32'h0000_0003);
    chk("R9 system reset pulse", 32'(hart_rst_o), 32'hF);
    @(negedge clk);
    chk("R9 pulse one cycle", 32'(hart_rst_o), 32'h0);
    wr(A_CTRL, 32'h0003_0005);
    chk("R9 hart reset only hart3", 32'(hart_rst_o), 32'h8);
    @(negedge clk);
    chk("R9 hart pulse ends", 32'(hart_rst_o), 32'h0);
  endtask

  task automatic t_reactivate;
    logic [31:0] v, c;
    wr(A_CTRL, 32'h8000_0001);
    wr(A_CTRL, 32'h4002_0001);
    rd(A_KEY, c);
    wr(A_CTRL, 32'h0000_0000);
    wr(A_CTRL, 32'h8001_0001);
    rd(A_STAT, v); chk("R3 activation clears auth", 32'(v[4]), 32'h0);
    chk("R3 activation clears halt", 32'(halt_req_o), 32'h0);
    chk("R3 activation clears resume", 32'(resume_req_o), 32'h0);
    rd(A_CTRL, v); chk("R3 activation clears fields", v, 32'h0000_0001);
    rd(A_KEY, v); chk("R3 new challenge", 32'(v != c), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_locked_ctrl();
    t_auth();
    t_halt();
    t_resume();
    t_have_reset();
    t_nonexist();
    t_reset_req();
    t_reactivate();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule